// File: doc/BRIEF.md
# Protected Address Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations. Each entry holds the virtual page number, the physical frame number, the owning process tag and three access attributes: writable, user-accessible and no-execute. When a lookup hits, the attributes are checked against the access type and the privilege level in the same step. A permitted access returns the physical address. A forbidden access returns a protection fault with a cause vector. Rights are never confirmed against the page table on a hit.

On a miss the block pulses a walk request that carries the page number and the process tag. The external page table walker answers at some later time with a refill. The refill carries a residency flag, and a page that is not resident is never cached. The requester retries the lookup after the refill. The whole cache can be invalidated in one cycle. A single page can also be invalidated for every process, which is used when that page leaves memory. Pages are 4 KB, so the low 12 address bits pass through unchanged.

Top module: `tlb_prot`

## Requirements
- R1: Each lookup request produces exactly one registered response one cycle later, with exactly one of hit, fault or miss set. Nothing is produced without a request, and after reset no response or walk request is active.
- R2: A permitted hit returns a physical address made of the entry's frame number above the request's untranslated 12-bit page offset, with a cause of zero.
- R3: A miss returns a physical address of zero and, in the same cycle, pulses the walk request with the virtual page number and process tag of the request.
- R4: An entry matches only when both its page number and its process tag equal those of the request; a valid entry owned by another process gives a miss.
- R5: The access type is encoded as 0 read, 1 write, 2 fetch. A write to an entry without write permission faults with cause bit 0 set.
- R6: A fetch from an entry marked no-execute faults with cause bit 1 set, while a read of the same entry hits.
- R7: A user-level access to an entry without user permission faults with cause bit 2 set, while a supervisor access hits on both user and supervisor entries.
- R8: A refill whose residency flag is clear installs nothing, so a later lookup of that page misses.
- R9: A refill for a page number and process tag already cached overwrites that entry in place. It does not consume a replacement slot, and no two valid entries ever match one lookup.
- R10: A refill for a new translation takes the slot under a round-robin pointer, which advances by one for each new allocation. After the pointer wraps, the oldest allocation is evicted first.
- R11: Asserting the flush-all input for one cycle invalidates every entry.
- R12: The single-page flush invalidates every entry with the given page number, whatever its process tag, and leaves all other entries valid.
- R13: A refill in the same cycle as a flush-all, or as a single-page flush of the same page, is dropped and does not advance the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-level access, 0 for supervisor |
| req_pid | input | PID_W | Process tag of the requester |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_miss | output | 1 | No matching translation |
| rsp_paddr | output | PA_W | Physical address on a hit, zero otherwise |
| rsp_cause | output | 3 | Fault cause: bit 0 write-protect, bit 1 no-execute, bit 2 privilege |
| walk_req | output | 1 | One-cycle request to the page table walker |
| walk_vpn | output | VA_W-12 | Page number to walk |
| walk_pid | output | PID_W | Process tag to walk |
| refill_valid | input | 1 | Refill strobe from the walker |
| refill_vpn | input | VA_W-12 | Refilled page number |
| refill_pid | input | PID_W | Refilled process tag |
| refill_pfn | input | PA_W-12 | Refilled frame number |
| refill_present | input | 1 | Page is resident; when clear, nothing is installed |
| refill_writable | input | 1 | Write permission |
| refill_user | input | 1 | User-level permission |
| refill_noexec | input | 1 | Fetch forbidden |
| flush_all | input | 1 | Invalidate every entry |
| flush_page | input | 1 | Invalidate entries matching flush_vpn |
| flush_vpn | input | VA_W-12 | Page number for the single-page flush |

## Verification
The bench aims at the places where a tag or replacement bug hides behind a correct-looking hit. It uses the same page under two process tags, so a design that ignores the tag would hit across processes, and a page flush that compares the tag would leave the second copy alive. It refills an entry that is already cached and then fills past capacity. A design that duplicates entries, or that advances the pointer on an overwrite or on a refill dropped because of a flush, evicts the wrong page, and a still-present or missing translation shows it. Each protection violation is probed next to an access to the same entry that is permitted, so a design that swaps or merges cause bits, or that faults on every access, gives the wrong cause or a false fault.

// File: rtl/tlb_prot_pkg.sv
package tlb_prot_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   localparam int CAUSE_W = 3;
   localparam int C_WP    = 0;
   localparam int C_NX    = 1;
   localparam int C_PRIV  = 2;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8
) (
   input  logic [ENTRIES-1:0]            ent_valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
   input  logic [ENTRIES-1:0][PID_W-1:0] ent_pid,
   input  logic [VPN_W-1:0]              key_vpn,
   input  logic [PID_W-1:0]              key_pid,
   input  logic                          pid_care,
   output logic [ENTRIES-1:0]            match
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign match[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) &&
                        (!pid_care || (ent_pid[i] == key_pid));
   end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
   import tlb_prot_pkg::*;
(
   input  acc_e               acc,
   input  logic               user_mode,
   input  logic               perm_wr,
   input  logic               perm_usr,
   input  logic               perm_nx,
   output logic [CAUSE_W-1:0] cause
);
   always_comb begin
      cause         = '0;
      cause[C_WP]   = (acc == ACC_WRITE) && !perm_wr;
      cause[C_NX]   = (acc == ACC_FETCH) && perm_nx;
      cause[C_PRIV] = user_mode && !perm_usr;
   end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   logic [IDX_W-1:0] ptr_q;

   if ((1 << IDX_W) == ENTRIES) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ptr_q <= '0;
         else if (adv) ptr_q <= ptr_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptr_q <= '0;
         else if (adv) begin
            if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
            else                              ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   assign ptr = ptr_q;

   a_r10_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
   import tlb_prot_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int PID_W   = 8,
   parameter int ENTRIES = 8,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PFN_W  = PA_W - OFF_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_acc,
   input  logic               req_user,
   input  logic [PID_W-1:0]   req_pid,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic               rsp_fault,
   output logic               rsp_miss,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [2:0]         rsp_cause,
   output logic               walk_req,
   output logic [VA_W-OFF_W-1:0] walk_vpn,
   output logic [PID_W-1:0]   walk_pid,
   input  logic               refill_valid,
   input  logic [VA_W-OFF_W-1:0] refill_vpn,
   input  logic [PID_W-1:0]   refill_pid,
   input  logic [PA_W-OFF_W-1:0] refill_pfn,
   input  logic               refill_present,
   input  logic               refill_writable,
   input  logic               refill_user,
   input  logic               refill_noexec,
   input  logic               flush_all,
   input  logic               flush_page,
   input  logic [VA_W-OFF_W-1:0] flush_vpn
);
   if (ENTRIES < 2)      begin : g_bad_depth $error("ENTRIES must be at least 2"); end
   if (VA_W <= OFF_W)    begin : g_bad_va    $error("VA_W must exceed OFF_W"); end
   if (PA_W <= OFF_W)    begin : g_bad_pa    $error("PA_W must exceed OFF_W"); end
   if (CAUSE_W != 3)     begin : g_bad_cause $error("cause width mismatch"); end

   // entry storage
   logic [ENTRIES-1:0]            v_q;
   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PID_W-1:0] pid_q;
   logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
   logic [ENTRIES-1:0]            wr_q, usr_q, nx_q;

   // lookup path
   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [PFN_W-1:0]   sel_pfn;
   logic               sel_wr, sel_usr, sel_nx;
   logic [CAUSE_W-1:0] lk_cause;

   assign lk_vpn = req_vaddr[VA_W-1:OFF_W];

   tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cam (
      .ent_valid(v_q), .ent_vpn(vpn_q), .ent_pid(pid_q),
      .key_vpn(lk_vpn), .key_pid(req_pid), .pid_care(1'b1), .match(lk_match));

   always_comb begin
      sel_pfn = '0;
      sel_wr  = 1'b0;
      sel_usr = 1'b0;
      sel_nx  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            sel_pfn = sel_pfn | pfn_q[i];
            sel_wr  = sel_wr  | wr_q[i];
            sel_usr = sel_usr | usr_q[i];
            sel_nx  = sel_nx  | nx_q[i];
         end
      end
   end
   assign lk_any = |lk_match;

   tlb_perm_check u_perm (
      .acc(acc_e'(req_acc)), .user_mode(req_user),
      .perm_wr(sel_wr), .perm_usr(sel_usr), .perm_nx(sel_nx), .cause(lk_cause));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_paddr <= '0;
         rsp_cause <= '0;
         walk_req  <= 1'b0;
         walk_vpn  <= '0;
         walk_pid  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && lk_any && (lk_cause == '0);
         rsp_fault <= req_valid && lk_any && (lk_cause != '0);
         rsp_miss  <= req_valid && !lk_any;
         rsp_paddr <= (req_valid && lk_any && (lk_cause == '0)) ?
                      {sel_pfn, req_vaddr[OFF_W-1:0]} : '0;
         rsp_cause <= (req_valid && lk_any) ? lk_cause : '0;
         walk_req  <= req_valid && !lk_any;
         if (req_valid && !lk_any) begin
            walk_vpn <= lk_vpn;
            walk_pid <= req_pid;
         end
      end
   end

   // refill and flush path
   logic [ENTRIES-1:0] rf_match, fl_match, wr_sel, ptr_hot;
   logic               rf_any, rf_take, rf_alloc;
   logic [IDX_W-1:0]   rr_ptr;

   tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_rf_cam (
      .ent_valid(v_q), .ent_vpn(vpn_q), .ent_pid(pid_q),
      .key_vpn(refill_vpn), .key_pid(refill_pid), .pid_care(1'b1), .match(rf_match));

   tlb_tag_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_cam (
      .ent_valid(v_q), .ent_vpn(vpn_q), .ent_pid(pid_q),
      .key_vpn(flush_vpn), .key_pid('0), .pid_care(1'b0), .match(fl_match));

   assign rf_any   = |rf_match;
   assign rf_take  = refill_valid && refill_present && !flush_all &&
                     !(flush_page && (flush_vpn == refill_vpn));
   assign rf_alloc = rf_take && !rf_any;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) ptr_hot[i] = (rr_ptr == IDX_W'(i));
   end
   assign wr_sel = !rf_take ? '0 : (rf_any ? rf_match : ptr_hot);

   tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
      .clk(clk), .rst_n(rst_n), .adv(rf_alloc), .ptr(rr_ptr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_sel[i]) v_q[i] <= 1'b1;
            if (flush_all || (flush_page && fl_match[i])) v_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_sel[i]) begin
            vpn_q[i] <= refill_vpn;
            pid_q[i] <= refill_pid;
            pfn_q[i] <= refill_pfn;
            wr_q[i]  <= refill_writable;
            usr_q[i] <= refill_user;
            nx_q[i]  <= refill_noexec;
         end
      end
   end

   // checks
   a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1);
   a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
   a_r3_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> rsp_valid && rsp_miss);
   a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all ##1 req_valid |=> rsp_miss);
endmodule

// File: tb/test_tlb_prot.sv
`timescale 1ns/1ps
module test_tlb_prot;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [7:0]  req_pid = '0;
   logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_cause;
   logic        walk_req;
   logic [19:0] walk_vpn;
   logic [7:0]  walk_pid;
   logic        refill_valid = 1'b0;
   logic [19:0] refill_vpn = '0;
   logic [7:0]  refill_pid = '0;
   logic [19:0] refill_pfn = '0;
   logic        refill_present = 1'b0, refill_writable = 1'b0;
   logic        refill_user = 1'b0, refill_noexec = 1'b0;
   logic        flush_all = 1'b0, flush_page = 1'b0;
   logic [19:0] flush_vpn = '0;

   always #2.5 clk = ~clk;

   tlb_prot i_tlb_prot (.*);

   localparam int K_HIT = 0, K_FAULT = 1, K_MISS = 2;
   typedef struct {
      int          kind;
      logic [31:0] pa;
      logic [2:0]  cause;
      logic [19:0] wvpn;
      logic [7:0]  wpid;
      int          due;
      string       tag;
   } exp_t;

   exp_t sb[$];
   exp_t e;
   int   tests = 0, fails = 0, cyc = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected items as responses appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            tests++;
            if (sb.size() == 0) begin
               fails++;
               $display("FAIL R1 unexpected response: got valid=1 expected none");
            end else begin
               int  gk;
               bit  ok;
               e  = sb.pop_front();
               gk = ({rsp_hit, rsp_fault, rsp_miss} == 3'b100) ? K_HIT :
                    ({rsp_hit, rsp_fault, rsp_miss} == 3'b010) ? K_FAULT :
                    ({rsp_hit, rsp_fault, rsp_miss} == 3'b001) ? K_MISS : 9;
               ok = (gk == e.kind) && (rsp_paddr == e.pa) && (rsp_cause == e.cause) &&
                    (cyc == e.due) && (walk_req == (e.kind == K_MISS));
               if (e.kind == K_MISS)
                  ok = ok && (walk_vpn == e.wvpn) && (walk_pid == e.wpid);
               if (!ok) begin
                  fails++;
                  $display("FAIL %s got kind=%0d pa=%h cause=%b walk=%b/%h/%h cyc=%0d expected kind=%0d pa=%h cause=%b walk=%h/%h cyc=%0d",
                           e.tag, gk, rsp_paddr, rsp_cause, walk_req, walk_vpn, walk_pid, cyc,
                           e.kind, e.pa, e.cause, e.wvpn, e.wpid, e.due);
               end
            end
         end else if (sb.size() > 0 && sb[0].due < cyc) begin
            tests++;
            fails++;
            e = sb.pop_front();
            $display("FAIL R1 %s missing response: got none expected at cyc %0d", e.tag, e.due);
         end
      end
   end

   task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                         input logic [7:0] pid, input int kind, input logic [31:0] pa,
                         input logic [2:0] cause, input string tag);
      exp_t x;
      @(negedge clk);
      x.kind = kind; x.pa = pa; x.cause = cause; x.wvpn = va[31:12]; x.wpid = pid;
      x.due = cyc + 1; x.tag = tag;
      sb.push_back(x);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr; req_pid = pid;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] pfn,
                         input logic w, input logic u, input logic nx, input logic pres);
      @(negedge clk);
      refill_valid = 1'b1; refill_vpn = vpn; refill_pid = pid; refill_pfn = pfn;
      refill_writable = w; refill_user = u; refill_noexec = nx; refill_present = pres;
      @(negedge clk);
      refill_valid = 1'b0;
   endtask

   task automatic do_flush_page(input logic [19:0] vpn);
      @(negedge clk);
      flush_page = 1'b1; flush_vpn = vpn;
      @(negedge clk);
      flush_page = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 20000);
      tests++;
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      tests++;
      if (rsp_valid !== 1'b0 || walk_req !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: got rsp_valid=%b walk_req=%b expected 0 0", rsp_valid, walk_req);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: cold miss raises a walk
      lookup(32'h0000_1234, 2'd0, 1'b0, 8'd1, K_MISS, 32'h0, 3'b000, "R3");
      refill(20'h00001, 8'd1, 20'hABCDE, 1, 1, 0, 1);
      // R2: hit passes the offset through
      lookup(32'h0000_1234, 2'd0, 1'b1, 8'd1, K_HIT, 32'hABCD_E234, 3'b000, "R2");
      lookup(32'h0000_1FF0, 2'd1, 1'b1, 8'd1, K_HIT, 32'hABCD_EFF0, 3'b000, "R2");
      // R4: other process misses
      lookup(32'h0000_1234, 2'd0, 1'b1, 8'd2, K_MISS, 32'h0, 3'b000, "R4");

      refill(20'h00002, 8'd1, 20'h22222, 0, 1, 1, 1);
      lookup(32'h0000_2010, 2'd1, 1'b1, 8'd1, K_FAULT, 32'h0, 3'b001, "R5");
      lookup(32'h0000_2010, 2'd2, 1'b1, 8'd1, K_FAULT, 32'h0, 3'b010, "R6");
      lookup(32'h0000_2010, 2'd0, 1'b1, 8'd1, K_HIT, 32'h2222_2010, 3'b000, "R6");

      refill(20'h00003, 8'd1, 20'h33333, 1, 0, 0, 1);
      lookup(32'h0000_3ABC, 2'd0, 1'b1, 8'd1, K_FAULT, 32'h0, 3'b100, "R7");
      lookup(32'h0000_3ABC, 2'd1, 1'b1, 8'd1, K_FAULT, 32'h0, 3'b100, "R7");
      lookup(32'h0000_3ABC, 2'd1, 1'b0, 8'd1, K_HIT, 32'h3333_3ABC, 3'b000, "R7");
      lookup(32'h0000_1004, 2'd0, 1'b0, 8'd1, K_HIT, 32'hABCD_E004, 3'b000, "R7");

      // R8: non-resident refill installs nothing
      refill(20'h00004, 8'd1, 20'h44444, 1, 1, 0, 0);
      lookup(32'h0000_4000, 2'd0, 1'b0, 8'd1, K_MISS, 32'h0, 3'b000, "R8");

      // R12: page flush hits every process, spares others
      refill(20'h00001, 8'd2, 20'h11112, 1, 1, 0, 1);
      lookup(32'h0000_1008, 2'd0, 1'b0, 8'd2, K_HIT, 32'h1111_2008, 3'b000, "R12");
      do_flush_page(20'h00001);
      lookup(32'h0000_1008, 2'd0, 1'b0, 8'd1, K_MISS, 32'h0, 3'b000, "R12");
      lookup(32'h0000_1008, 2'd0, 1'b0, 8'd2, K_MISS, 32'h0, 3'b000, "R12");
      lookup(32'h0000_2008, 2'd0, 1'b0, 8'd1, K_HIT, 32'h2222_2008, 3'b000, "R12");

      // R13: same-cycle page flush drops the refill
      @(negedge clk);
      refill_valid = 1'b1; refill_vpn = 20'h00005; refill_pid = 8'd1; refill_pfn = 20'h55555;
      refill_writable = 1; refill_user = 1; refill_noexec = 0; refill_present = 1;
      flush_page = 1'b1; flush_vpn = 20'h00005;
      @(negedge clk);
      refill_valid = 1'b0; flush_page = 1'b0;
      lookup(32'h0000_5000, 2'd0, 1'b0, 8'd1, K_MISS, 32'h0, 3'b000, "R13");

      // R11: flush all
      @(negedge clk);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
      lookup(32'h0000_2008, 2'd0, 1'b0, 8'd1, K_MISS, 32'h0, 3'b000, "R11");
      lookup(32'h0000_3008, 2'd0, 1'b0, 8'd1, K_MISS, 32'h0, 3'b000, "R11");

      // R9 / R10: fill all slots, overwrite one, then evict the oldest
      for (int i = 0; i < 8; i++) refill(20'h00010 + 20'(i), 8'd7, 20'h00100 + 20'(i), 1, 1, 0, 1);
      refill(20'h00013, 8'd7, 20'h00999, 1, 1, 0, 1);
      for (int i = 0; i < 8; i++)
         lookup({20'h00010 + 20'(i), 12'h0A0}, 2'd0, 1'b0, 8'd7, K_HIT,
                {(i == 3) ? 20'h00999 : 20'h00100 + 20'(i), 12'h0A0}, 3'b000, "R9");
      refill(20'h00018, 8'd7, 20'h00188, 1, 1, 0, 1);
      lookup(32'h0001_00A0, 2'd0, 1'b0, 8'd7, K_MISS, 32'h0, 3'b000, "R10");
      for (int i = 1; i < 9; i++)
         lookup({20'h00010 + 20'(i), 12'h0A0}, 2'd0, 1'b0, 8'd7, K_HIT,
                {(i == 3) ? 20'h00999 : ((i == 8) ? 20'h00188 : 20'h00100 + 20'(i)), 12'h0A0},
                3'b000, "R10");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         tests++;
         fails++;
         $display("FAIL R1 leftover: got %0d pending expected 0", sb.size());
      end
      finish_run();
   end
endmodule